// File: doc/BRIEF.md
# Six-Pin Bidirectional Port with Clock Output

This block is a small general-purpose I/O port for a microcontroller register bus. Six pads are each served by one bit of an output value register and one bit of a direction register. A direction bit of 1 turns on that pad's output driver; 0 leaves the pad as an input whose level software can read. The register interface is a plain synchronous one: an address, a write strobe and write data, sampled on the rising bus clock edge, and a combinational read data word selected by the address.

One pad, pin 2, can be handed over to a clock-out function. A dedicated enable bit in the direction register makes that pad drive the system clock and turns on its driver, whatever its own direction bit says. Reset clears the direction register and the clock-out enable, so every pad comes up as an input. The output value register has no reset and keeps what it held through a reset. Pad levels pass through a two-stage synchronizer before they reach the read path.

Top module: `gpio_port_clko`

## Requirements
- R1: A write to offset 0x02 loads bits 5..0 of the write data into the output value register on that clock edge, whatever the pins' directions. `pad_out` shows the value on the next cycle (pin 2 excepted while clock output is on).
- R2: A write to offset 0x06 loads bits 5..0 into the direction register. On the next cycle `pad_oe[i]` is 1 exactly when direction bit i is 1 (pin 2 excepted while clock output is on).
- R3: Bit 6 of offset 0x06 is the clock-output enable. While it is 1, `pad_oe[2]` is 1 and `pad_out[2]` follows `sys_clk` combinationally.
- R4: While the clock-output enable is 1, direction bit 2 has no effect on `pad_oe[2]` or `pad_out[2]`.
- R5: Reset (`rst_n` low, asynchronous) clears direction bits 5..0 and the clock-output enable. `pad_oe` is all zeros and offset 0x06 reads 0x00.
- R6: Reset leaves the output value register unchanged. `pad_out` keeps its value during and after reset.
- R7: Bit 7 at offset 0x06 and bits 7..6 at offset 0x02 always read 0. Writing 1s to them has no effect. Writing 0xFF to 0x06 reads back 0x7F.
- R8: A read of offset 0x02 returns, for each pin, the register bit when the pin is an output and the synchronized pad level when it is an input. A pad change becomes visible to reads after the second rising edge, not the first.
- R9: While the clock-output enable is 1, bit 2 of a read at offset 0x02 is the output value register bit, not the pad level or the clock.
- R10: Reads from any offset other than 0x02 and 0x06 return 0x00. Writes to those offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all registers and the synchronizer use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_clk | input | 1 | System clock driven out on pin 2 when clock output is on |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge of clk |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on bus_addr (combinational) |
| pad_in | input | 6 | Pad input levels (asynchronous) |
| pad_out | output | 6 | Value driven on each pad when its driver is on |
| pad_oe | output | 6 | Per-pad output driver enable |

## Verification
A corrupt direction bit or clock-output enable shows on `pad_oe` and on pin 2's `pad_out` in the same cycle, and a readback of offset 0x06 shows it as soon as the address is presented. A wrong output value bit appears on `pad_out` directly. It also appears in a data readback once that pin is set as an output, because an input pin hides the register behind the synchronized pad level. A synchronizer with the wrong depth shows as a pad change visible one edge too early or too late. The bench checks the exact edge count for this.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Width of the register bus data path.
  localparam int BUS_W = 8;

  // Select, bit by bit, between the stored output value and the sampled pad
  // level: a 1 in drive_mask picks the stored value.
  function automatic logic [BUS_W-1:0] merge_read(
    input logic [BUS_W-1:0] stored,
    input logic [BUS_W-1:0] sampled,
    input logic [BUS_W-1:0] drive_mask
  );
    return (stored & drive_mask) | (sampled & ~drive_mask);
  endfunction

  // Pack the direction bits and the clock-output enable into a bus word.
  function automatic logic [BUS_W-1:0] pack_dir(
    input logic [BUS_W-2:0] dir_bits,
    input logic             clk_en,
    input int               en_pos
  );
    logic [BUS_W-1:0] w;
    w = {1'b0, dir_bits};
    w[en_pos] = clk_en;
    return w;
  endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NPIN     = 6,
  parameter int DATA_OFS = 2,
  parameter int DIR_OFS  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [BUS_W-1:0]  wdata,
  output logic [NPIN-1:0]   value_q,
  output logic [NPIN-1:0]   dir_q,
  output logic              clk_en_q,
  output logic              data_sel,
  output logic              dir_sel
);

  localparam int EN_POS = NPIN;

  logic value_wr;
  logic dir_wr;

  assign data_sel = (addr == ADDR_W'(DATA_OFS));
  assign dir_sel  = (addr == ADDR_W'(DIR_OFS));
  assign value_wr = we & data_sel;
  assign dir_wr   = we & dir_sel;

  // Output value register: deliberately has no reset.
  always_ff @(posedge clk) begin
    if (value_wr) value_q <= wdata[NPIN-1:0];
  end

  // Direction register and clock-output enable: cleared by reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      clk_en_q <= 1'b0;
    end else if (dir_wr) begin
      dir_q    <= wdata[NPIN-1:0];
      clk_en_q <= wdata[EN_POS];
    end
  end

  // Reserved write bits are dropped.
  logic unused_wbits;
  assign unused_wbits = &{1'b0, wdata[BUS_W-1:EN_POS+1]};

endmodule

// File: rtl/gpio_port_padmux.sv
module gpio_port_padmux #(
  parameter int NPIN     = 6,
  parameter int CLKO_PIN = 2
) (
  input  logic [NPIN-1:0] value_q,
  input  logic [NPIN-1:0] dir_q,
  input  logic            clk_en,
  input  logic            sys_clk,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] rd_mask
);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    if (i == CLKO_PIN) begin : g_clko
      // Clock override takes the pin regardless of its direction bit;
      // the read path still reports the stored bit.
      assign pad_out[i] = clk_en ? sys_clk : value_q[i];
      assign pad_oe[i]  = clk_en | dir_q[i];
      assign rd_mask[i] = clk_en | dir_q[i];
    end else begin : g_plain
      assign pad_out[i] = value_q[i];
      assign pad_oe[i]  = dir_q[i];
      assign rd_mask[i] = dir_q[i];
    end
  end

endmodule

// File: rtl/gpio_port_clko.sv
module gpio_port_clko
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int NPIN        = 6,
  parameter int CLKO_PIN    = 2,
  parameter int DATA_OFS    = 2,
  parameter int DIR_OFS     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_clk,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe
);

  localparam int EN_POS = NPIN;

  logic [NPIN-1:0]  value_q;
  logic [NPIN-1:0]  dir_q;
  logic             clk_en_q;
  logic             data_sel;
  logic             dir_sel;
  logic [NPIN-1:0]  pad_sync;
  logic [NPIN-1:0]  rd_mask;
  logic [BUS_W-1:0] data_word;
  logic [BUS_W-1:0] dir_word;

  gpio_port_sync #(
    .WIDTH  (NPIN),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  gpio_port_regs #(
    .ADDR_W   (ADDR_W),
    .NPIN     (NPIN),
    .DATA_OFS (DATA_OFS),
    .DIR_OFS  (DIR_OFS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .value_q  (value_q),
    .dir_q    (dir_q),
    .clk_en_q (clk_en_q),
    .data_sel (data_sel),
    .dir_sel  (dir_sel)
  );

  gpio_port_padmux #(
    .NPIN     (NPIN),
    .CLKO_PIN (CLKO_PIN)
  ) u_padmux (
    .value_q (value_q),
    .dir_q   (dir_q),
    .clk_en  (clk_en_q),
    .sys_clk (sys_clk),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .rd_mask (rd_mask)
  );

  assign data_word = merge_read(BUS_W'(value_q), BUS_W'(pad_sync), BUS_W'(rd_mask));
  assign dir_word  = pack_dir((BUS_W-1)'(dir_q), clk_en_q, EN_POS);

  always_comb begin
    if (data_sel)     bus_rdata = data_word;
    else if (dir_sel) bus_rdata = dir_word;
    else              bus_rdata = '0;
  end

endmodule

// File: rtl/gpio_port_clko_chk.sv
module gpio_port_clko_chk #(
  parameter int ADDR_W   = 4,
  parameter int NPIN     = 6,
  parameter int CLKO_PIN = 2,
  parameter int DATA_OFS = 2,
  parameter int DIR_OFS  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_clk,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe,
  input logic              clk_en
);

  localparam logic [NPIN-1:0] OTHER = ~(NPIN'(1) << CLKO_PIN);

  assert_value_to_pad_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(DATA_OFS)) |=>
      ((pad_out & OTHER) == ($past(bus_wdata[NPIN-1:0]) & OTHER)));

  assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(DIR_OFS)) |=>
      ((pad_oe & OTHER) == ($past(bus_wdata[NPIN-1:0]) & OTHER)));

  assert_clk_on_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(DIR_OFS) && bus_wdata[NPIN]) |=>
      (pad_oe[CLKO_PIN] && (pad_out[CLKO_PIN] == sys_clk)));

  assert_dir_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> pad_oe[CLKO_PIN]);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_oe_R5: assert (pad_oe == '0);
    end
  end

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(DIR_OFS)) |-> (bus_rdata[7:NPIN+1] == '0));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(DIR_OFS) && bus_addr != ADDR_W'(DATA_OFS)) |-> (bus_rdata == '0));

endmodule

bind gpio_port_clko gpio_port_clko_chk #(
  .ADDR_W   (ADDR_W),
  .NPIN     (NPIN),
  .CLKO_PIN (CLKO_PIN),
  .DATA_OFS (DATA_OFS),
  .DIR_OFS  (DIR_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sys_clk   (sys_clk),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .clk_en    (clk_en_q)
);

// File: tb/sim_gpio_port_clko.sv
`timescale 1ns/1ps
module sim_gpio_port_clko;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_clk = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [5:0] pad_in = 6'h00;
  logic [5:0] pad_out;
  logic [5:0] pad_oe;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_port_clko u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_clk   (sys_clk),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  // Fields: req, write offset (FF = no write), write data, pad level,
  // read offset, expected read data.
  localparam int NV = 9;
  localparam logic [47:0] VEC [0:NV-1] = '{
    48'h01_02_2A_00_02_00,  // R1/R8: value stored, inputs read pads
    48'h02_06_3F_15_02_2A,  // R2/R8: all outputs read stored value
    48'h08_06_0F_15_02_1A,  // R8: mixed directions
    48'h07_06_FF_00_06_7F,  // R7: reserved dir bit reads 0
    48'h07_02_FF_00_02_3F,  // R7: reserved data bits read 0
    48'h09_06_40_00_02_04,  // R9: clock out, bit 2 from stored value
    48'h0A_05_00_00_05_00,  // R10: unmapped offset
    48'h0A_FF_00_00_06_40,  // R10: dir untouched by unmapped write
    48'h08_06_00_2A_02_2A   // R8: all inputs
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    // Reset state (R5)
    repeat (2) @(negedge clk);
    check("R5 oe in reset", {2'b0, pad_oe}, 8'h00);
    read_reg(4'h6, rd);
    check("R5 dir in reset", rd, 8'h00);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [47:0] v;
      v = VEC[k];
      @(negedge clk);
      pad_in = v[21:16];
      if (v[39:32] != 8'hFF) write_reg(v[35:32], v[31:24]);
      repeat (3) @(negedge clk);
      read_reg(v[11:8], rd);
      check($sformatf("R%0d vector %0d", v[47:40], k), rd, v[7:0]);
    end

    // R2: direction drives output enables
    write_reg(4'h6, 8'h15);
    check("R2 oe", {2'b0, pad_oe}, 8'h15);
    // R1: stored value on pads
    write_reg(4'h2, 8'h0A);
    check("R1 pad_out", {2'b0, pad_out}, 8'h0A);

    // R3: clock out on pin 2 (stored bit 2 is 0)
    write_reg(4'h6, 8'h40);
    sys_clk = 1'b0; #1;
    check("R3 pin2 low", {7'b0, pad_out[2]}, 8'h00);
    sys_clk = 1'b1; #1;
    check("R3 pin2 high", {7'b0, pad_out[2]}, 8'h01);
    check("R3 oe", {2'b0, pad_oe}, 8'h04);
    // R4: direction bit 2 has no effect
    write_reg(4'h6, 8'h44);
    check("R4 oe dir2=1", {2'b0, pad_oe}, 8'h04);
    check("R4 out dir2=1", {7'b0, pad_out[2]}, 8'h01);
    write_reg(4'h6, 8'h40);
    check("R4 oe dir2=0", {2'b0, pad_oe}, 8'h04);
    // R9: read bit 2 is the stored bit, not the pad or clock
    pad_in = 6'h3F;
    repeat (3) @(negedge clk);
    read_reg(4'h2, rd);
    check("R9 read", rd, 8'h3B);

    // R8: two-edge synchronizer latency
    write_reg(4'h6, 8'h00);
    pad_in = 6'h00;
    repeat (3) @(negedge clk);
    pad_in = 6'h11;
    @(negedge clk);
    read_reg(4'h2, rd);
    check("R8 after one edge", rd, 8'h00);
    @(negedge clk);
    read_reg(4'h2, rd);
    check("R8 after two edges", rd, 8'h11);

    // R10: unmapped write changes nothing
    write_reg(4'h3, 8'hFF);
    check("R10 pad_out", {2'b0, pad_out}, 8'h0A);
    check("R10 oe", {2'b0, pad_oe}, 8'h00);
    read_reg(4'h3, rd);
    check("R10 read", rd, 8'h00);

    // R5/R6: reset clears direction, keeps stored value
    write_reg(4'h2, 8'h35);
    write_reg(4'h6, 8'h7F);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R5 oe after reset", {2'b0, pad_oe}, 8'h00);
    read_reg(4'h6, rd);
    check("R5 dir after reset", rd, 8'h00);
    check("R6 pad_out in reset", {2'b0, pad_out}, 8'h35);
    @(negedge clk);
    rst_n = 1'b1;
    write_reg(4'h6, 8'h3F);
    read_reg(4'h2, rd);
    check("R6 readback", rd, 8'h35);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule